// File: doc/BRIEF.md
# Two-Bank GPIO with Change Interrupt

A memory-mapped GPIO block with one or two banks of pins, each bank up to 32 pins wide. Every bank holds an output-value register and a direction register, so a pin either reads the outside world or drives the stored value. Pin inputs cross into the clock domain through two flops. A bank whose input-configured pins move in any direction raises that bank's pending bit.

Software reaches the block through a plain 32-bit port: a word address, a single-cycle write strobe, write data, and read data that follows the address combinationally. Pending bits are cleared by writing ones. The interrupt line combines the pending bits, a per-bank enable and one master enable.

Top module: `banked_gpio`

## Requirements
- R1: After reset every direction bit is 1, so all output enables are low. Each bank's output value equals its DOUT_INIT parameter. Pending bits, bank enables and the master enable are 0, and `irq` is low.
- R2: Bank A's value register is at offset 0x0 and its direction register at 0x4. Bank B uses 0x8 and 0xC. A direction bit of 0 makes the pin an output: `pin_oe` is that bit inverted and `pin_out` is the written value.
- R3: A read of a bank's value offset returns the synchronised pin levels. A pin change is visible on the second rising edge after it, and bits at or above the bank width read as 0.
- R4: A read of a direction offset returns the direction register, zero-extended.
- R5: Bit 0 (bank A) or bit 1 (bank B) of the pending register at 0x120 is set on the third rising edge after any rising or falling change of an input pin of that bank.
- R6: A change on a pin configured as output, or above the bank width, does not set a pending bit.
- R7: Writing 1 to a pending bit clears it and writing 0 leaves it unchanged. Writing back a value just read clears exactly those bits.
- R8: When a new change reaches a pending bit on the same edge as a write that clears it, the bit stays set.
- R9: `irq` is high exactly when bit 31 of 0x11C is set and the AND of the pending register with the enable register at 0x128 (same bit layout) is non-zero.
- R10: Unmapped offsets read as 0 and writes to them change nothing. With DUAL=0, bank B offsets read 0, bank B outputs stay 0, and bit 1 of the pending and enable registers reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| pin_in_a | input | WIDTH_A | Bank A pin levels |
| pin_out_a | output | WIDTH_A | Bank A output values |
| pin_oe_a | output | WIDTH_A | Bank A output enables, high = drive |
| pin_in_b | input | WIDTH_B | Bank B pin levels |
| pin_out_b | output | WIDTH_B | Bank B output values |
| pin_oe_b | output | WIDTH_B | Bank B output enables, high = drive |
| irq | output | 1 | Interrupt request |

## Verification
Register writes take effect on the edge where the strobe is high, so `pin_out`, `pin_oe`, `irq` and read data are sampled on the falling edge that follows. A pin change shows in the value register after two edges and in the pending register after three. The bench therefore changes pins on a falling edge and waits four falling edges before it samples either register. For the collision case the clearing write is timed to cover exactly the third edge after the change.

// File: rtl/gpio_map_pkg.sv
package gpio_map_pkg;
   localparam int unsigned MAP_W      = 9;
   localparam int unsigned OFS_VAL_A  = 'h000;
   localparam int unsigned OFS_DIR_A  = 'h004;
   localparam int unsigned OFS_VAL_B  = 'h008;
   localparam int unsigned OFS_DIR_B  = 'h00C;
   localparam int unsigned OFS_MASTER = 'h11C;
   localparam int unsigned OFS_PEND   = 'h120;
   localparam int unsigned OFS_ENA    = 'h128;
   localparam int unsigned MASTER_BIT = 31;
   localparam int unsigned BUS_W      = 32;
endpackage

// File: rtl/gpio_bank.sv
module gpio_bank #(
   parameter int unsigned   W         = 32,
   parameter logic [W-1:0]  DOUT_INIT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_val,
   input  logic         wr_dir,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] pin_in,
   output logic [W-1:0] pin_out,
   output logic [W-1:0] pin_oe,
   output logic [W-1:0] level,
   output logic [W-1:0] dir,
   output logic         change
);
   logic [W-1:0] val_q, dir_q, meta_q, sync_q, hist_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_q  <= DOUT_INIT;
         dir_q  <= '1;
         meta_q <= '0;
         sync_q <= '0;
         hist_q <= '0;
      end else begin
         if (wr_val) val_q <= wdata;
         if (wr_dir) dir_q <= wdata;
         meta_q <= pin_in;
         sync_q <= meta_q;
         hist_q <= sync_q;
      end
   end

   assign pin_out = val_q;
   assign pin_oe  = ~dir_q;
   assign level   = sync_q;
   assign dir     = dir_q;
   assign change  = |((sync_q ^ hist_q) & dir_q);

   // R1: reset leaves every pin an input with the default value
   assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (pin_oe == '0) && (pin_out == DOUT_INIT));
   // R2: enables move only on a direction write
   assert_oe_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_dir |=> $stable(pin_oe));
endmodule

// File: rtl/gpio_pend.sv
module gpio_pend #(
   parameter int unsigned NCH = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] change,
   input  logic           wr_pend,
   input  logic           wr_ena,
   input  logic           wr_master,
   input  logic [NCH-1:0] wbits,
   input  logic           wmaster,
   output logic [NCH-1:0] pend,
   output logic [NCH-1:0] ena,
   output logic           master,
   output logic           irq
);
   logic [NCH-1:0] pend_q, ena_q, clr;
   logic           master_q;

   assign clr = wr_pend ? wbits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q   <= '0;
         ena_q    <= '0;
         master_q <= 1'b0;
      end else begin
         pend_q <= (pend_q & ~clr) | change;
         if (wr_ena)    ena_q    <= wbits;
         if (wr_master) master_q <= wmaster;
      end
   end

   assign pend   = pend_q;
   assign ena    = ena_q;
   assign master = master_q;
   assign irq    = master_q & |(pend_q & ena_q);

   for (genvar i = 0; i < NCH; i++) begin : g_chk
      // R5: a detected change sets the bank bit on the next edge
      assert_set_on_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
         change[i] |=> pend_q[i]);
      // R7: a bit not written with 1 holds
      assert_pend_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
         pend_q[i] && !clr[i] |=> pend_q[i]);
      // R7: a write of 1 with no change clears
      assert_pend_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
         clr[i] && !change[i] |=> !pend_q[i]);
   end
   // R9: master enable gates the line
   assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !master_q |-> !irq);
endmodule

// File: rtl/banked_gpio.sv
module banked_gpio
   import gpio_map_pkg::*;
#(
   parameter int unsigned         ADDR_W      = 9,
   parameter int unsigned         WIDTH_A     = 32,
   parameter int unsigned         WIDTH_B     = 32,
   parameter bit                  DUAL        = 1'b1,
   parameter logic [WIDTH_A-1:0]  DOUT_INIT_A = '0,
   parameter logic [WIDTH_B-1:0]  DOUT_INIT_B = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic               reg_we,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   input  logic [WIDTH_A-1:0] pin_in_a,
   output logic [WIDTH_A-1:0] pin_out_a,
   output logic [WIDTH_A-1:0] pin_oe_a,
   input  logic [WIDTH_B-1:0] pin_in_b,
   output logic [WIDTH_B-1:0] pin_out_b,
   output logic [WIDTH_B-1:0] pin_oe_b,
   output logic               irq
);
   localparam int unsigned NCH = DUAL ? 2 : 1;

   if (WIDTH_A < 1 || WIDTH_A > BUS_W) begin : g_bad_wa
      $error("WIDTH_A must be 1..32");
   end
   if (WIDTH_B < 1 || WIDTH_B > BUS_W) begin : g_bad_wb
      $error("WIDTH_B must be 1..32");
   end
   if (ADDR_W < MAP_W) begin : g_bad_aw
      $error("ADDR_W too small for the register map");
   end

   logic hit_val_a, hit_dir_a, hit_val_b, hit_dir_b, hit_master, hit_pend, hit_ena;
   assign hit_val_a  = reg_addr == ADDR_W'(OFS_VAL_A);
   assign hit_dir_a  = reg_addr == ADDR_W'(OFS_DIR_A);
   assign hit_val_b  = DUAL && (reg_addr == ADDR_W'(OFS_VAL_B));
   assign hit_dir_b  = DUAL && (reg_addr == ADDR_W'(OFS_DIR_B));
   assign hit_master = reg_addr == ADDR_W'(OFS_MASTER);
   assign hit_pend   = reg_addr == ADDR_W'(OFS_PEND);
   assign hit_ena    = reg_addr == ADDR_W'(OFS_ENA);

   logic [WIDTH_A-1:0] level_a, dir_a;
   logic [WIDTH_B-1:0] level_b, dir_b;
   logic [NCH-1:0]     change, pend, ena;
   logic               master;

   gpio_bank #(.W(WIDTH_A), .DOUT_INIT(DOUT_INIT_A)) u_bank_a (
      .clk(clk), .rst_n(rst_n),
      .wr_val(reg_we && hit_val_a), .wr_dir(reg_we && hit_dir_a),
      .wdata(reg_wdata[WIDTH_A-1:0]), .pin_in(pin_in_a),
      .pin_out(pin_out_a), .pin_oe(pin_oe_a),
      .level(level_a), .dir(dir_a), .change(change[0]));

   if (DUAL) begin : g_bank_b
      gpio_bank #(.W(WIDTH_B), .DOUT_INIT(DOUT_INIT_B)) u_bank_b (
         .clk(clk), .rst_n(rst_n),
         .wr_val(reg_we && hit_val_b), .wr_dir(reg_we && hit_dir_b),
         .wdata(reg_wdata[WIDTH_B-1:0]), .pin_in(pin_in_b),
         .pin_out(pin_out_b), .pin_oe(pin_oe_b),
         .level(level_b), .dir(dir_b), .change(change[NCH-1]));
   end else begin : g_no_b
      assign pin_out_b = '0;
      assign pin_oe_b  = '0;
      assign level_b   = '0;
      assign dir_b     = '0;
   end

   gpio_pend #(.NCH(NCH)) u_pend (
      .clk(clk), .rst_n(rst_n), .change(change),
      .wr_pend(reg_we && hit_pend), .wr_ena(reg_we && hit_ena),
      .wr_master(reg_we && hit_master),
      .wbits(reg_wdata[NCH-1:0]), .wmaster(reg_wdata[MASTER_BIT]),
      .pend(pend), .ena(ena), .master(master), .irq(irq));

   always_comb begin
      reg_rdata = '0;
      if (hit_val_a)  reg_rdata = 32'(level_a);
      if (hit_dir_a)  reg_rdata = 32'(dir_a);
      if (hit_val_b)  reg_rdata = 32'(level_b);
      if (hit_dir_b)  reg_rdata = 32'(dir_b);
      if (hit_master) reg_rdata[MASTER_BIT] = master;
      if (hit_pend)   reg_rdata = 32'(pend);
      if (hit_ena)    reg_rdata = 32'(ena);
   end
endmodule

// File: tb/test_banked_gpio.sv
`timescale 1ns/1ps
module test_banked_gpio;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [8:0]  addr = '0, addr_s = '0;
   logic        we = 1'b0, we_s = 1'b0;
   logic [31:0] wdata = '0, wdata_s = '0, rdata, rdata_s;
   logic [31:0] in_a = '0, in_b = '0, out_a, oe_a, out_b, oe_b;
   logic [7:0]  in_a_s = '0, out_a_s, oe_a_s;
   logic [31:0] in_b_s = '0, out_b_s, oe_b_s;
   logic        irq, irq_s;

   banked_gpio i_banked_gpio (
      .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_we(we), .reg_wdata(wdata),
      .reg_rdata(rdata), .pin_in_a(in_a), .pin_out_a(out_a), .pin_oe_a(oe_a),
      .pin_in_b(in_b), .pin_out_b(out_b), .pin_oe_b(oe_b), .irq(irq));

   banked_gpio #(.WIDTH_A(8), .DUAL(1'b0), .DOUT_INIT_A(8'hA5)) i_banked_gpio_small (
      .clk(clk), .rst_n(rst_n), .reg_addr(addr_s), .reg_we(we_s), .reg_wdata(wdata_s),
      .reg_rdata(rdata_s), .pin_in_a(in_a_s), .pin_out_a(out_a_s), .pin_oe_a(oe_a_s),
      .pin_in_b(in_b_s), .pin_out_b(out_b_s), .pin_oe_b(oe_b_s), .irq(irq_s));

   int n_run = 0, n_fail = 0;
   bit done = 0;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [8:0] a, logic [31:0] d);
      @(negedge clk); addr = a; wdata = d; we = 1'b1;
      @(negedge clk); we = 1'b0;
   endtask
   task automatic rd(logic [8:0] a, output logic [31:0] d);
      @(negedge clk); addr = a; #1 d = rdata;
   endtask
   task automatic wr_s(logic [8:0] a, logic [31:0] d);
      @(negedge clk); addr_s = a; wdata_s = d; we_s = 1'b1;
      @(negedge clk); we_s = 1'b0;
   endtask
   task automatic rd_s(logic [8:0] a, output logic [31:0] d);
      @(negedge clk); addr_s = a; #1 d = rdata_s;
   endtask
   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   function automatic logic [31:0] exp_pend(logic [31:0] pa, na, da, pb, nb, db);
      return {30'd0, |((pb ^ nb) & db), |((pa ^ na) & da)};
   endfunction

   initial begin
      logic [31:0] v, da, db, na, nb;
      void'($urandom(32'd1357));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 oe_a", oe_a, 32'h0);
      chk("R1 oe_b", oe_b, 32'h0);
      chk("R1 out_a", out_a, 32'h0);
      chk("R1 irq", {31'd0, irq}, 32'h0);
      chk("R1 small out", {24'd0, out_a_s}, 32'hA5);
      rd(9'h004, v); chk("R1/R4 dir_a reads ones", v, 32'hFFFF_FFFF);
      rd(9'h120, v); chk("R1 pend", v, 32'h0);
      rd(9'h11C, v); chk("R1 master", v, 32'h0);

      // R2 outputs follow value and direction
      wr(9'h000, 32'h1234_5678);
      wr(9'h004, 32'h0000_FFFF);
      @(negedge clk);
      chk("R2 out_a", out_a, 32'h1234_5678);
      chk("R2 oe_a", oe_a, 32'hFFFF_0000);
      wr(9'h008, 32'hCAFE_F00D);
      wr(9'h00C, 32'h0F0F_0F0F);
      @(negedge clk);
      chk("R2 out_b", out_b, 32'hCAFE_F00D);
      chk("R2 oe_b", oe_b, 32'hF0F0_F0F0);
      rd(9'h00C, v); chk("R4 dir_b", v, 32'h0F0F_0F0F);

      // R6 change on output pins only
      wr(9'h120, 32'h3);
      in_a = 32'hFFFF_0000; in_b = 32'hF0F0_F0F0;
      settle();
      rd(9'h120, v); chk("R6 output pins ignored", v, 32'h0);
      // R3 value read returns pin level
      rd(9'h000, v); chk("R3 level a", v, 32'hFFFF_0000);
      rd(9'h008, v); chk("R3 level b", v, 32'hF0F0_F0F0);

      // R3 two-edge latency
      @(negedge clk); addr = 9'h000; in_a = 32'hFFFF_0001;
      @(negedge clk); #1 chk("R3 not yet after one edge", rdata, 32'hFFFF_0000);
      @(negedge clk); #1 chk("R3 visible after two edges", rdata, 32'hFFFF_0001);
      settle();
      rd(9'h120, v); chk("R5 input pin rise", v, 32'h1);

      // R7 partial clear and write-back
      in_b = 32'hF0F0_F0F1; settle();
      rd(9'h120, v); chk("R5 both set", v, 32'h3);
      wr(9'h120, 32'h2);
      rd(9'h120, v); chk("R7 clear bit1 only", v, 32'h1);
      wr(9'h120, 32'h0);
      rd(9'h120, v); chk("R7 zero write holds", v, 32'h1);
      in_a = 32'hFFFF_0000; settle();
      rd(9'h120, v); chk("R5 falling edge", v, 32'h1);
      wr(9'h120, v);
      rd(9'h120, v); chk("R7 write-back clears", v, 32'h0);

      // R9 interrupt gating
      in_a = 32'hFFFF_0001; settle();
      wr(9'h128, 32'h1); @(negedge clk);
      chk("R9 master off", {31'd0, irq}, 32'h0);
      wr(9'h11C, 32'h8000_0000); @(negedge clk);
      chk("R9 asserted", {31'd0, irq}, 32'h1);
      rd(9'h11C, v); chk("R9 master readback", v, 32'h8000_0000);
      wr(9'h128, 32'h2); @(negedge clk);
      chk("R9 enable mismatch", {31'd0, irq}, 32'h0);
      wr(9'h128, 32'h1); wr(9'h120, 32'h1); @(negedge clk);
      chk("R9 cleared", {31'd0, irq}, 32'h0);
      wr(9'h128, 32'h0); wr(9'h11C, 32'h0);

      // R8 change on the clearing edge wins
      in_a = 32'hFFFF_0000; settle();
      rd(9'h120, v); chk("R8 precondition", v, 32'h1);
      @(negedge clk); in_a = 32'hFFFF_0001;
      @(negedge clk);
      @(negedge clk); addr = 9'h120; wdata = 32'h1; we = 1'b1;
      @(negedge clk); we = 1'b0;
      rd(9'h120, v); chk("R8 set wins", v, 32'h1);
      wr(9'h120, 32'h1);
      rd(9'h120, v); chk("R8 later clear", v, 32'h0);

      // R10 unmapped offsets
      wr(9'h010, 32'hFFFF_FFFF);
      rd(9'h010, v); chk("R10 unmapped read", v, 32'h0);
      rd(9'h004, v); chk("R10 unmapped write ignored", v, 32'h0000_FFFF);

      // random stimulus for R5/R6/R3
      for (int k = 0; k < 40; k++) begin
         da = $urandom; db = $urandom;
         na = $urandom; nb = $urandom;
         if (k % 5 == 0) begin na = in_a; nb = in_b; end
         wr(9'h004, da); wr(9'h00C, db);
         wr(9'h120, 32'h3);
         v = exp_pend(in_a, na, da, in_b, nb, db);
         in_a = na; in_b = nb;
         settle();
         rd(9'h120, wdata); chk("R5/R6 random pend", wdata, v);
         rd(9'h000, wdata); chk("R3 random level a", wdata, na);
         rd(9'h008, wdata); chk("R3 random level b", wdata, nb);
      end

      // small instance: width 8, single bank
      rd_s(9'h008, v); chk("R10 absent bank value", v, 32'h0);
      wr_s(9'h00C, 32'hFFFF_FFFF);
      rd_s(9'h00C, v); chk("R10 absent bank dir", v, 32'h0);
      chk("R10 absent bank oe", oe_b_s, 32'h0);
      wr_s(9'h128, 32'h3);
      rd_s(9'h128, v); chk("R10 enable bit1 absent", v, 32'h1);
      in_b_s = 32'hFFFF_FFFF; settle();
      rd_s(9'h120, v); chk("R10 absent bank no pend", v, 32'h0);
      in_a_s = 8'hFF; settle();
      rd_s(9'h000, v); chk("R3 narrow bank level", v, 32'h0000_00FF);
      rd_s(9'h004, v); chk("R4 narrow dir", v, 32'h0000_00FF);
      rd_s(9'h120, v); chk("R5 narrow pend", v, 32'h1);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule